// File: doc/BRIEF.md
# Master-Tick Clock-Enable Sequencer

This block divides one fast master clock into clock-enable strobes for a pixel pipeline and for a processor whose speed is chosen at run time. A free-running tick counter walks through a 16-tick frame. The video strobe and the processor strobe sit on fixed, interleaved tick positions, so the two never fire on the same master tick. With a 56 MHz master clock, the video strobe runs at 14 MHz. The processor strobe runs at 3.5, 7, 14 or an average of 21 MHz.

Software selects the processor rate by writing the low two bits of a hardware-control byte. The new rate is held as pending and takes effect only at the start of the next frame. Because of this, no processor strobe is ever shortened or repeated at a switch. The block also drives a frame-start strobe, the current tick number and the rate now in force. A downstream contention circuit can use these to line up with the video fetch slots.

Top module: `clk_strobe_seq`

## Requirements
- R1: While `rst` is high, every registered output reads idle: `video_ce`, `cpu_ce` and `frame_start` are 0, `tick_num` is all ones (15), and `speed_active` is 00 (3.5 MHz, the default rate).
- R2: `tick_num` advances by one on every master clock and wraps from 15 to 0. The first value after reset is released is 0, one clock after the first active edge.
- R3: `frame_start` is 1 exactly when `tick_num` is 0.
- R4: `video_ce` is 1 on ticks 2, 6, 10 and 14, whatever the processor rate.
- R5: With `speed_active` = 00, `cpu_ce` is 1 on tick 0 only.
- R6: With `speed_active` = 01, `cpu_ce` is 1 on ticks 0 and 8.
- R7: With `speed_active` = 10, `cpu_ce` is 1 on ticks 0, 4, 8 and 12.
- R8: With `speed_active` = 11, `cpu_ce` is 1 on ticks 0, 3, 5, 8, 11 and 13, which is six strobes per frame.
- R9: `cpu_ce` and `video_ce` are never 1 in the same cycle.
- R10: A cycle with `ctl_wr` high loads `ctl_wdata[1:0]` as the pending rate (00 = 3.5, 01 = 7, 10 = 14, 11 = 21 MHz). Bits 7..2 of the written byte have no effect.
- R11: The pending rate reaches `speed_active` and the `cpu_ce` pattern only at the next `frame_start`. The rest of the frame in progress keeps the old pattern, and `speed_active` changes only in a cycle where `frame_start` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the hardware-control byte |
| ctl_wdata | input | 8 | Control byte; bits 1..0 give the processor rate |
| video_ce | output | 1 | Pixel pipeline clock enable |
| cpu_ce | output | 1 | Processor clock enable |
| frame_start | output | 1 | High on tick 0 of each frame |
| tick_num | output | 4 | Tick number that the enables of this cycle belong to |
| speed_active | output | 2 | Processor rate code now in force |

## Verification
Every output is registered, so the strobes for a tick appear one clock after the counter holds that tick. `tick_num` always reports the tick that the current enables belong to, and the bench compares enables against `tick_num` rather than against its own clock count. A write lands on the edge that follows the cycle in which the bench drives it. The new rate is therefore due at the first `frame_start` after that edge, and the bench checks every tick between the write and that frame boundary against the old pattern. Stimulus changes and sampling both take place on the falling edge, half a period away from the edges that update the design.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  typedef enum logic [1:0] {
    SPD_X1 = 2'd0,
    SPD_X2 = 2'd1,
    SPD_X4 = 2'd2,
    SPD_X6 = 2'd3
  } cpu_speed_e;

  localparam int unsigned NUM_SPEEDS = 4;
endpackage

// File: rtl/clkseq_tick_counter.sv
module clkseq_tick_counter #(
  parameter int unsigned FRAME_TICKS = 16,
  localparam int unsigned TW = $clog2(FRAME_TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] tick,
  output logic          frame_end
);
  localparam logic [TW-1:0] LAST = TW'(FRAME_TICKS - 1);

  logic [TW-1:0] tick_q;

  assign frame_end = (tick_q == LAST);
  assign tick      = tick_q;

  always_ff @(posedge clk) begin
    if (rst)            tick_q <= '0;
    else if (frame_end) tick_q <= '0;
    else                tick_q <= tick_q + 1'b1;
  end
endmodule

// File: rtl/clkseq_speed_latch.sv
module clkseq_speed_latch
  import clkseq_pkg::*;
#(
  parameter int unsigned CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             frame_end,
  output cpu_speed_e       active
);
  cpu_speed_e pend_q;
  cpu_speed_e active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= SPD_X1;
      active_q <= SPD_X1;
    end else begin
      if (wr_en)     pend_q   <= cpu_speed_e'(wr_data[1:0]);
      if (frame_end) active_q <= pend_q;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/clkseq_strobe_decode.sv
module clkseq_strobe_decode
  import clkseq_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 16,
  parameter logic [FRAME_TICKS-1:0] VID_MASK    = 16'h4444,
  parameter logic [FRAME_TICKS-1:0] CPU_MASK_X1 = 16'h0001,
  parameter logic [FRAME_TICKS-1:0] CPU_MASK_X2 = 16'h0101,
  parameter logic [FRAME_TICKS-1:0] CPU_MASK_X4 = 16'h1111,
  parameter logic [FRAME_TICKS-1:0] CPU_MASK_X6 = 16'h2929,
  localparam int unsigned TW = $clog2(FRAME_TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tick,
  input  cpu_speed_e    speed,
  output logic          video_ce,
  output logic          cpu_ce,
  output logic          frame_start,
  output logic [TW-1:0] tick_out,
  output logic [1:0]    speed_out
);
  localparam logic [NUM_SPEEDS*FRAME_TICKS-1:0] ALL_MASKS =
    {CPU_MASK_X6, CPU_MASK_X4, CPU_MASK_X2, CPU_MASK_X1};

  logic [NUM_SPEEDS-1:0] hit;

  for (genvar g = 0; g < NUM_SPEEDS; g++) begin : g_speed
    logic [FRAME_TICKS-1:0] mask;
    assign mask   = ALL_MASKS[g*FRAME_TICKS +: FRAME_TICKS];
    assign hit[g] = mask[tick];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      video_ce    <= 1'b0;
      cpu_ce      <= 1'b0;
      frame_start <= 1'b0;
      tick_out    <= '1;
      speed_out   <= SPD_X1;
    end else begin
      video_ce    <= VID_MASK[tick];
      cpu_ce      <= hit[speed];
      frame_start <= (tick == '0);
      tick_out    <= tick;
      speed_out   <= speed;
    end
  end
endmodule

// File: rtl/clk_strobe_seq.sv
module clk_strobe_seq
  import clkseq_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 16,
  parameter int unsigned CTL_W = 8,
  parameter logic [FRAME_TICKS-1:0] VID_MASK    = 16'h4444,
  parameter logic [FRAME_TICKS-1:0] CPU_MASK_X1 = 16'h0001,
  parameter logic [FRAME_TICKS-1:0] CPU_MASK_X2 = 16'h0101,
  parameter logic [FRAME_TICKS-1:0] CPU_MASK_X4 = 16'h1111,
  parameter logic [FRAME_TICKS-1:0] CPU_MASK_X6 = 16'h2929,
  localparam int unsigned TW = $clog2(FRAME_TICKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             video_ce,
  output logic             cpu_ce,
  output logic             frame_start,
  output logic [TW-1:0]    tick_num,
  output logic [1:0]       speed_active
);
  logic [TW-1:0] tick;
  logic          frame_end;
  cpu_speed_e    speed;

  clkseq_tick_counter #(.FRAME_TICKS(FRAME_TICKS)) i_counter (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .frame_end (frame_end)
  );

  clkseq_speed_latch #(.CTL_W(CTL_W)) i_latch (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ctl_wr),
    .wr_data   (ctl_wdata),
    .frame_end (frame_end),
    .active    (speed)
  );

  clkseq_strobe_decode #(
    .FRAME_TICKS (FRAME_TICKS),
    .VID_MASK    (VID_MASK),
    .CPU_MASK_X1 (CPU_MASK_X1),
    .CPU_MASK_X2 (CPU_MASK_X2),
    .CPU_MASK_X4 (CPU_MASK_X4),
    .CPU_MASK_X6 (CPU_MASK_X6)
  ) i_decode (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .speed       (speed),
    .video_ce    (video_ce),
    .cpu_ce      (cpu_ce),
    .frame_start (frame_start),
    .tick_out    (tick_num),
    .speed_out   (speed_active)
  );
endmodule

// File: rtl/clk_strobe_seq_chk.sv
module clk_strobe_seq_chk #(
  parameter int unsigned FRAME_TICKS = 16,
  localparam int unsigned TW = $clog2(FRAME_TICKS)
) (
  input logic          clk,
  input logic          rst,
  input logic          video_ce,
  input logic          cpu_ce,
  input logic          frame_start,
  input logic [TW-1:0] tick_num,
  input logic [1:0]    speed_active
);
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tick_num == TW'($past(tick_num) + 1'b1)); // R2

  AST_FRAME_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> tick_num == '0); // R3

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(cpu_ce && video_ce)); // R9

  AST_CPU_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> cpu_ce); // R5

  AST_SPEED_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (speed_active != $past(speed_active)) -> frame_start); // R11
endmodule

bind clk_strobe_seq clk_strobe_seq_chk #(.FRAME_TICKS(FRAME_TICKS)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .video_ce     (video_ce),
  .cpu_ce       (cpu_ce),
  .frame_start  (frame_start),
  .tick_num     (tick_num),
  .speed_active (speed_active)
);

// File: tb/test_clk_strobe_seq.sv
module test_clk_strobe_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       video_ce, cpu_ce, frame_start;
  logic [3:0] tick_num;
  logic [1:0] speed_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [15:0] VID_EXP = 16'h4444;
  // {write byte, expected rate code, expected cpu tick mask}
  localparam logic [25:0] VEC [4] = '{
    {8'hFD, 2'd1, 16'h0101},   // R6, upper bits set (R10)
    {8'h02, 2'd2, 16'h1111},   // R7
    {8'h03, 2'd3, 16'h2929},   // R8
    {8'h00, 2'd0, 16'h0001}    // R5
  };

  always #10 clk = ~clk;

  clk_strobe_seq i_clk_strobe_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .video_ce(video_ce), .cpu_ce(cpu_ce), .frame_start(frame_start),
    .tick_num(tick_num), .speed_active(speed_active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_wdata = d;
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_frame();
    while (!frame_start) @(negedge clk);
  endtask

  // Checks one full frame starting at the current negedge (tick 0).
  task automatic check_frame(input logic [1:0] spd, input logic [15:0] cmask, input string req);
    int n;
    n = 0;
    for (int t = 0; t < 16; t++) begin
      chk(tick_num == 4'(t), "R2 tick", tick_num, t);
      chk(frame_start == (t == 0), "R3 frame_start", frame_start, int'(t == 0));
      chk(video_ce == VID_EXP[t], "R4 video_ce", video_ce, VID_EXP[t]);
      chk(cpu_ce == cmask[t], req, cpu_ce, cmask[t]);
      chk(!(cpu_ce && video_ce), "R9 overlap", cpu_ce, 0);
      chk(speed_active == spd, "R11 speed_active", speed_active, spd);
      if (cpu_ce) n++;
      @(negedge clk);
    end
    chk(n == $countones(cmask), {req, " count"}, n, $countones(cmask));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(video_ce == 0 && cpu_ce == 0 && frame_start == 0, "R1 enables", {video_ce, cpu_ce, frame_start}, 0);
    chk(tick_num == 4'hF, "R1 tick_num", tick_num, 15);
    chk(speed_active == 2'd0, "R1 speed", speed_active, 0);
    rst = 1'b0;
    @(negedge clk);
    // R2 first tick after release, default rate R5
    chk(tick_num == 0 && frame_start == 1, "R2 first tick", tick_num, 0);
    check_frame(2'd0, 16'h0001, "R5 cpu_ce");

    // Table walk: R5..R8, R10
    for (int v = 0; v < 4; v++) begin
      wait_frame();
      wr(VEC[v][25:18]);
      wait_frame();
      check_frame(VEC[v][17:16], VEC[v][15:0], "R5-8 table cpu_ce");
    end

    // R11: mid-frame switch from 21 MHz to 7 MHz
    wait_frame();
    wr(8'h03);
    wait_frame();
    while (tick_num != 4'd5) @(negedge clk);
    wr(8'h01);
    for (int t = 6; t < 16; t++) begin
      chk(tick_num == 4'(t), "R11 tick", tick_num, t);
      chk(cpu_ce == VEC[2][t], "R11 old pattern", cpu_ce, VEC[2][t]);
      chk(speed_active == 2'd3, "R11 old speed", speed_active, 3);
      @(negedge clk);
    end
    check_frame(2'd1, 16'h0101, "R11 new pattern");

    // R10: upper bits only, rate 01 must stay
    wait_frame();
    wr(8'hFD);
    wait_frame();
    check_frame(2'd1, 16'h0101, "R10 upper bits ignored");

    // R1: reset restores default rate
    rst = 1'b1;
    @(negedge clk);
    chk(speed_active == 2'd0 && tick_num == 4'hF, "R1 re-reset", speed_active, 0);
    rst = 1'b0;
    @(negedge clk);
    check_frame(2'd0, 16'h0001, "R1 default after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule